// File: doc/BRIEF.md
# Per-thread fetch address and miss controller

This block holds the next instruction fetch address for each of several hardware threads and decides, per thread, whether that thread may be offered to the fetch arbiter. Each cycle a thread's address is redirected by a flush, reloaded with a missing address, advanced to the next 16-byte fetch group when the thread is granted, or held. Around instruction cache misses it keeps at most one line request per thread in flight toward the L2. It parks a second miss until the first line comes back.

When a line returns it either writes it into the cache or drops it, depending on whether the thread is still fetching in the same 2 KB region. A written fill blocks fetch for every thread for a fixed window while the single-ported data array is busy. A back-invalidation from the L2 blocks fetch for one cycle. The arbiter combines `fetch_en` with `fetch_stall`. The cache arrays and the L2 protocol beyond a valid-only request and return are outside this block.

Top module: `fetch_ctl`

## Requirements
- R1: After reset every thread address equals `RST_ADDR` (default 0), `fetch_en` is all ones, and `fetch_stall` and `l2_req_vld` are low.
- R2: A grant to an enabled thread, with no stall, sets that thread's address to the start of the next 16-byte group, `(addr + 16)` with bits 3:0 cleared, on the next edge. Threads that are not granted keep their addresses.
- R3: A grant is ignored while the granted thread is disabled or while `fetch_stall` is high.
- R4: A flush sets the thread's address to `flush_tgt` on the next edge, taking priority over a miss and a grant in the same cycle. It re-enables the thread and discards any miss queued for it.
- R5: A miss on a thread with no request in flight loads `miss_addr` into its address and clears its `fetch_en` bit. From the following cycle, `l2_req_vld` is high for exactly one cycle carrying that thread and address.
- R6: A miss on a thread whose request is still in flight is queued and issues no request. Its request goes out in the cycle after the first line returns, and the thread stays disabled until the second line returns.
- R7: A returning line re-enables a waiting thread that has no queued miss.
- R8: In the cycle `fill_vld` is high, `fill_wr` is high when bits 31:11 of the thread's current address equal those of `fill_line`; otherwise `fill_drop` is high. Exactly one of the two is high.
- R9: A written fill holds `fetch_stall` high for the four cycles after it; a dropped fill causes no stall.
- R10: A back-invalidation holds `fetch_stall` high for the one cycle after it. When it coincides with a written fill, the longer window applies.
- R11: When several threads have a request ready, one request is issued per cycle, lowest thread index first.
- R12: After a flush re-enables a thread whose request is still in flight, the thread can be granted and advances normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_vld | input | 1 | Arbiter granted a thread this cycle |
| grant_tid | input | 2 | Granted thread |
| flush_vld | input | 1 | Redirect a thread |
| flush_tid | input | 2 | Thread being redirected |
| flush_tgt | input | 32 | Redirect byte address |
| miss_vld | input | 1 | Instruction cache miss reported |
| miss_tid | input | 2 | Thread that missed |
| miss_addr | input | 32 | Missing fetch address |
| fill_vld | input | 1 | L2 line returned |
| fill_tid | input | 2 | Thread the line belongs to |
| fill_line | input | 32 | Address of the returned line |
| binv_vld | input | 1 | L2 back-invalidation pulse |
| fetch_addr | output | 128 | Next fetch address, thread t at bits 32t+31:32t |
| fetch_en | output | 4 | Thread may be offered to the arbiter |
| l2_req_vld | output | 1 | Line request to the L2 |
| l2_req_tid | output | 2 | Requesting thread |
| l2_req_addr | output | 32 | Requested address |
| fill_wr | output | 1 | Write the returned line into the cache |
| fill_drop | output | 1 | Discard the returned line |
| fetch_stall | output | 1 | Global fetch block |

## Verification
Two collisions matter most. In the first, a line return for one thread lands in the same cycle as a fresh miss on another thread. The return frees that thread's queued request while the new miss creates a second one. The bench provokes this and expects the lower thread's request, then the higher one's, on consecutive cycles with a quiet port afterwards. In the second, a back-invalidation arrives in the same cycle as a written fill, and the stall must last the full four cycles rather than one.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
    localparam int ADDR_W     = 32;
    localparam int GRP_LOG    = 4;
    localparam int REGION_LOG = 11;

    typedef logic [ADDR_W-1:0] addr_t;

    function automatic addr_t next_group(addr_t a);
        addr_t step;
        addr_t mask;
        step = addr_t'(1) << GRP_LOG;
        mask = step - addr_t'(1);
        return (a + step) & ~mask;
    endfunction

    function automatic logic same_region(addr_t a, addr_t b);
        return a[ADDR_W-1:REGION_LOG] == b[ADDR_W-1:REGION_LOG];
    endfunction
endpackage

// File: rtl/fctl_thread.sv
module fctl_thread
    import fctl_pkg::*;
#(
    parameter addr_t RST_ADDR = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush_i,
    input  addr_t flush_tgt_i,
    input  logic  miss_i,
    input  addr_t miss_addr_i,
    input  logic  grant_i,
    input  logic  fill_i,
    input  logic  issue_i,
    output addr_t addr_o,
    output logic  en_o,
    output logic  ready_o,
    output addr_t pend_addr_o
);
    typedef struct packed {
        addr_t addr;
        addr_t pend_addr;
        logic  hold;
        logic  pend;
        logic  busy;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue_i) begin
            st_d.busy = 1'b1;
            st_d.pend = 1'b0;
        end
        if (fill_i) begin
            st_d.busy = 1'b0;
            if (!st_q.pend) st_d.hold = 1'b0;
        end
        if (flush_i) begin
            st_d.addr = flush_tgt_i;
            st_d.hold = 1'b0;
            st_d.pend = 1'b0;
        end else if (miss_i) begin
            st_d.addr      = miss_addr_i;
            st_d.hold      = 1'b1;
            st_d.pend      = 1'b1;
            st_d.pend_addr = miss_addr_i;
        end else if (grant_i) begin
            st_d.addr = next_group(st_q.addr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{RST_ADDR, '0, 1'b0, 1'b0, 1'b0};
        else        st_q <= st_d;
    end

    assign addr_o      = st_q.addr;
    assign en_o        = !st_q.hold;
    assign ready_o     = st_q.pend && !st_q.busy;
    assign pend_addr_o = st_q.pend_addr;

    // R6
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> !st_q.busy);
    // R4
    flush_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> en_o);
    // R5
    miss_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && !flush_i) |=> !en_o);
    // R3
    parked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !flush_i && !miss_i) |=> addr_o == $past(addr_o));
    // R6
    queued_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && st_q.pend && !flush_i) |=> !en_o);
endmodule

// File: rtl/fctl_reqsel.sv
module fctl_reqsel
    import fctl_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int TID_W = $clog2(NTHR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTHR-1:0]        ready_i,
    input  logic [NTHR*ADDR_W-1:0] pend_addr_i,
    output logic                   vld_o,
    output logic [TID_W-1:0]       tid_o,
    output addr_t                  addr_o,
    output logic [NTHR-1:0]        issue_o
);
    always_comb begin
        vld_o   = 1'b0;
        tid_o   = '0;
        addr_o  = '0;
        issue_o = '0;
        for (int t = NTHR - 1; t >= 0; t--) begin
            if (ready_i[t]) begin
                vld_o   = 1'b1;
                tid_o   = TID_W'(t);
                addr_o  = pend_addr_i[t*ADDR_W +: ADDR_W];
                issue_o = NTHR'(1) << t;
            end
        end
    end

    // R11
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_o));
    // R11
    issue_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ready_i[tid_o]);
endmodule

// File: rtl/fctl_stall.sv
module fctl_stall #(
    parameter int FILL_CYC = 4,
    parameter int BINV_CYC = 1,
    parameter int MAX_CYC  = (FILL_CYC > BINV_CYC) ? FILL_CYC : BINV_CYC,
    parameter int CW       = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fill_wr_i,
    input  logic binv_i,
    output logic stall_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q != '0) ? cnt_q - CW'(1) : '0;
        if (binv_i && cnt_d < CW'(BINV_CYC))    cnt_d = CW'(BINV_CYC);
        if (fill_wr_i && cnt_d < CW'(FILL_CYC)) cnt_d = CW'(FILL_CYC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stall_o = cnt_q != '0;

    // R9
    fill_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_wr_i |=> stall_o);
    // R10
    binv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_i |=> stall_o);
    // R9
    no_spurious_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_wr_i && !binv_i && !stall_o) |=> !stall_o);
endmodule

// File: rtl/fetch_ctl.sv
module fetch_ctl
    import fctl_pkg::*;
#(
    parameter int    NTHR       = 4,
    parameter int    TID_W      = $clog2(NTHR),
    parameter addr_t RST_ADDR   = '0,
    parameter int    FILL_STALL = 4,
    parameter int    BINV_STALL = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   grant_vld,
    input  logic [TID_W-1:0]       grant_tid,
    input  logic                   flush_vld,
    input  logic [TID_W-1:0]       flush_tid,
    input  logic [ADDR_W-1:0]      flush_tgt,
    input  logic                   miss_vld,
    input  logic [TID_W-1:0]       miss_tid,
    input  logic [ADDR_W-1:0]      miss_addr,
    input  logic                   fill_vld,
    input  logic [TID_W-1:0]       fill_tid,
    input  logic [ADDR_W-1:0]      fill_line,
    input  logic                   binv_vld,
    output logic [NTHR*ADDR_W-1:0] fetch_addr,
    output logic [NTHR-1:0]        fetch_en,
    output logic                   l2_req_vld,
    output logic [TID_W-1:0]       l2_req_tid,
    output logic [ADDR_W-1:0]      l2_req_addr,
    output logic                   fill_wr,
    output logic                   fill_drop,
    output logic                   fetch_stall
);
    addr_t                  thr_addr [NTHR];
    logic [NTHR-1:0]        thr_ready;
    logic [NTHR-1:0]        thr_issue;
    logic [NTHR*ADDR_W-1:0] thr_pend;
    addr_t                  fill_cur;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic grant_ok;
        assign grant_ok = grant_vld && (grant_tid == TID_W'(t))
                          && fetch_en[t] && !fetch_stall;

        fctl_thread #(.RST_ADDR(RST_ADDR)) u_thr (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_vld && flush_tid == TID_W'(t)),
            .flush_tgt_i (flush_tgt),
            .miss_i      (miss_vld && miss_tid == TID_W'(t)),
            .miss_addr_i (miss_addr),
            .grant_i     (grant_ok),
            .fill_i      (fill_vld && fill_tid == TID_W'(t)),
            .issue_i     (thr_issue[t]),
            .addr_o      (thr_addr[t]),
            .en_o        (fetch_en[t]),
            .ready_o     (thr_ready[t]),
            .pend_addr_o (thr_pend[t*ADDR_W +: ADDR_W])
        );
        assign fetch_addr[t*ADDR_W +: ADDR_W] = thr_addr[t];
    end

    fctl_reqsel #(.NTHR(NTHR), .TID_W(TID_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (thr_ready),
        .pend_addr_i (thr_pend),
        .vld_o       (l2_req_vld),
        .tid_o       (l2_req_tid),
        .addr_o      (l2_req_addr),
        .issue_o     (thr_issue)
    );

    assign fill_cur  = thr_addr[fill_tid];
    assign fill_wr   = fill_vld && same_region(fill_cur, fill_line);
    assign fill_drop = fill_vld && !same_region(fill_cur, fill_line);

    fctl_stall #(.FILL_CYC(FILL_STALL), .BINV_CYC(BINV_STALL)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_wr_i (fill_wr),
        .binv_i    (binv_vld),
        .stall_o   (fetch_stall)
    );

    // R8
    fill_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |-> (fill_wr != fill_drop));
    // R8
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_vld |-> !(fill_wr || fill_drop));
endmodule

// File: tb/sim_fetch_ctl.sv
module sim_fetch_ctl;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         grant_vld, flush_vld, miss_vld, fill_vld, binv_vld;
    logic [1:0]   grant_tid, flush_tid, miss_tid, fill_tid;
    logic [31:0]  flush_tgt, miss_addr, fill_line;
    logic [127:0] fetch_addr;
    logic [3:0]   fetch_en;
    logic         l2_req_vld;
    logic [1:0]   l2_req_tid;
    logic [31:0]  l2_req_addr;
    logic         fill_wr, fill_drop, fetch_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    fetch_ctl u0 (.*);

    // fields: is_flush(1) tid(2) addr(32) expected(32)
    localparam logic [66:0] VECS [0:6] = '{
        {1'b0, 2'd0, 32'h0,    32'h10},
        {1'b0, 2'd0, 32'h0,    32'h20},
        {1'b1, 2'd1, 32'h1237, 32'h1237},
        {1'b0, 2'd1, 32'h0,    32'h1240},
        {1'b1, 2'd2, 32'h5000, 32'h5000},
        {1'b0, 2'd2, 32'h0,    32'h5010},
        {1'b0, 2'd3, 32'h0,    32'h10}
    };

    function automatic logic [31:0] fa(int t);
        return fetch_addr[t*32 +: 32];
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle();
        grant_vld = 0; flush_vld = 0; miss_vld = 0; fill_vld = 0; binv_vld = 0;
        grant_tid = 0; flush_tid = 0; miss_tid = 0; fill_tid = 0;
        flush_tgt = 0; miss_addr = 0; fill_line = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic req_chk(input string rq, input logic v, input logic [1:0] t, input logic [31:0] a);
        chk(l2_req_vld == v, rq, 32'(l2_req_vld), 32'(v));
        if (v) begin
            chk(l2_req_tid == t, rq, 32'(l2_req_tid), 32'(t));
            chk(l2_req_addr == a, rq, l2_req_addr, a);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_up();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        chk(fetch_en == 4'hF, "R1 en", 32'(fetch_en), 32'hF);
        chk(fetch_addr == '0, "R1 addr", fa(3), 0);
        chk(!fetch_stall, "R1 stall", 32'(fetch_stall), 0);
        chk(!l2_req_vld, "R1 req", 32'(l2_req_vld), 0);

        // R2 R4 table of grants and flushes
        foreach (VECS[i]) begin
            if (VECS[i][66]) begin
                flush_vld = 1; flush_tid = VECS[i][65:64]; flush_tgt = VECS[i][63:32];
            end else begin
                grant_vld = 1; grant_tid = VECS[i][65:64];
            end
            cyc();
            chk(fa(int'(VECS[i][65:64])) == VECS[i][31:0], "R2/R4 table",
                fa(int'(VECS[i][65:64])), VECS[i][31:0]);
        end
        chk(fa(0) == 32'h20, "R2 untouched", fa(0), 32'h20);

        // R4 flush beats miss and grant in the same cycle
        flush_vld = 1; flush_tid = 1; flush_tgt = 32'h800;
        miss_vld = 1; miss_tid = 1; miss_addr = 32'h900;
        grant_vld = 1; grant_tid = 1;
        cyc();
        chk(fa(1) == 32'h800, "R4 priority", fa(1), 32'h800);
        chk(fetch_en[1], "R4 enabled", 32'(fetch_en[1]), 1);
        req_chk("R4 no req", 0, 0, 0);

        // R5 miss on idle thread
        miss_vld = 1; miss_tid = 0; miss_addr = 32'h2040;
        cyc();
        chk(fa(0) == 32'h2040, "R5 addr", fa(0), 32'h2040);
        chk(!fetch_en[0], "R5 disabled", 32'(fetch_en[0]), 0);
        req_chk("R5 req", 1, 0, 32'h2040);
        grant_vld = 1; grant_tid = 0;
        cyc();
        req_chk("R5 single pulse", 0, 0, 0);
        chk(fa(0) == 32'h2040, "R3 disabled grant", fa(0), 32'h2040);

        // R12 flush while in flight, then fetch
        flush_vld = 1; flush_tid = 0; flush_tgt = 32'h3000;
        cyc();
        chk(fetch_en[0], "R12 enabled", 32'(fetch_en[0]), 1);
        grant_vld = 1; grant_tid = 0;
        cyc();
        chk(fa(0) == 32'h3010, "R12 advance", fa(0), 32'h3010);

        // R6 second miss queued
        miss_vld = 1; miss_tid = 0; miss_addr = 32'h3010;
        cyc();
        chk(!fetch_en[0], "R6 disabled", 32'(fetch_en[0]), 0);
        req_chk("R6 held", 0, 0, 0);
        cyc();
        req_chk("R6 still held", 0, 0, 0);

        // R8 stale region: drop
        fill_vld = 1; fill_tid = 0; fill_line = 32'h2040;
        #1;
        chk(fill_drop && !fill_wr, "R8 drop", {30'd0, fill_wr, fill_drop}, 32'h1);
        cyc();
        chk(!fetch_stall, "R9 drop no stall", 32'(fetch_stall), 0);
        chk(!fetch_en[0], "R6 off until second", 32'(fetch_en[0]), 0);
        req_chk("R6 second req", 1, 0, 32'h3010);
        cyc();
        req_chk("R6 one pulse", 0, 0, 0);

        // R8 same region: write; R7 re-enable; R9 four-cycle stall
        fill_vld = 1; fill_tid = 0; fill_line = 32'h3000;
        #1;
        chk(fill_wr && !fill_drop, "R8 write", {30'd0, fill_wr, fill_drop}, 32'h2);
        cyc();
        chk(fetch_en[0], "R7 re-enabled", 32'(fetch_en[0]), 1);
        chk(fetch_stall, "R9 stall 1", 32'(fetch_stall), 1);
        grant_vld = 1; grant_tid = 2;
        cyc();
        chk(fa(2) == 32'h5010, "R3 stall grant", fa(2), 32'h5010);
        for (int k = 2; k <= 3; k++) begin
            chk(fetch_stall, "R9 stall window", 32'(fetch_stall), 1);
            cyc();
        end
        chk(fetch_stall, "R9 stall 4", 32'(fetch_stall), 1);
        cyc();
        chk(!fetch_stall, "R9 stall end", 32'(fetch_stall), 0);

        // R10 lone back-invalidation
        binv_vld = 1;
        cyc();
        chk(fetch_stall, "R10 one cycle", 32'(fetch_stall), 1);
        cyc();
        chk(!fetch_stall, "R10 end", 32'(fetch_stall), 0);

        // R10 back-invalidation with written fill
        miss_vld = 1; miss_tid = 1; miss_addr = 32'h4000;
        cyc();
        req_chk("R5 t1 req", 1, 1, 32'h4000);
        cyc();
        fill_vld = 1; fill_tid = 1; fill_line = 32'h4000; binv_vld = 1;
        cyc();
        for (int k = 1; k <= 4; k++) begin
            chk(fetch_stall, "R10 overlap window", 32'(fetch_stall), 1);
            cyc();
        end
        chk(!fetch_stall, "R10 overlap end", 32'(fetch_stall), 0);

        // R11 two ready requests in one cycle
        miss_vld = 1; miss_tid = 2; miss_addr = 32'h6000;
        cyc();
        cyc();
        flush_vld = 1; flush_tid = 2; flush_tgt = 32'h6800;
        cyc();
        miss_vld = 1; miss_tid = 2; miss_addr = 32'h6800;
        cyc();
        req_chk("R6 t2 held", 0, 0, 0);
        fill_vld = 1; fill_tid = 2; fill_line = 32'h6000;
        miss_vld = 1; miss_tid = 3; miss_addr = 32'h7000;
        cyc();
        req_chk("R11 first low index", 1, 2, 32'h6800);
        cyc();
        req_chk("R11 then next", 1, 3, 32'h7000);
        cyc();
        req_chk("R11 quiet", 0, 0, 0);

        finish_up();
    end
endmodule